// File: doc/BRIEF.md
# Configurable JK Gated Latch

This block is a bit-vector JK storage element controlled by a gate level. Each clock cycle in which the gate sits at its active level, every bit of the stored word is updated from its own pair of j and k bits: hold, force to 0, force to 1 or invert. While the gate is inactive the word is held. Parameters set the active level of j, k and gate independently. An inverted copy of the output can be switched on.

Three control inputs shape the update. An enable, a preset and a clear can each be immediate (asynchronous), gate-qualified (synchronous) or absent, and each can be active high or active low. Preset and clear load two separate constant vectors, and clear wins when both are active. An immediate control overrides the output in the same cycle it is asserted, whatever the gate and enable are doing. A gate-qualified control takes effect at the next clock edge, and only if the gate is active. The level-sensitive gating is evaluated once per clock, which keeps the toggle case deterministic. A synchronous active-low reset loads zeros when initialization is enabled.

Top module: `jk_gated_latch`

## Requirements
- R1: With the gate active, all enables satisfied and no preset or clear active, each bit of q takes its next value at the next clock edge from its own j,k pair: 00 holds, 01 gives 0, 10 gives 1, 11 gives the inverse of the current bit.
- R2: A j, k or gate input configured active-low is inverted before R1 is applied. For example, a raw j bit of 0 acts as a j of 1.
- R3: While the gate is inactive, no j/k update and no gate-qualified preset or clear takes place, and q holds.
- R4: With an immediate enable that is inactive, q holds at the next edge even while the gate is active. Gate-qualified preset and clear are blocked as well. Immediate preset and clear still act.
- R5: A gate-qualified enable is looked at only while the gate is active. When it is inactive, j/k updates are blocked, but gate-qualified preset and clear still load.
- R6: An active immediate clear (or preset) drives q to CLR_VAL (or PRE_VAL) in the same cycle, regardless of gate and enable. The stored word takes that value at the next edge.
- R7: A gate-qualified clear (or preset) loads CLR_VAL (or PRE_VAL) at the next edge, provided the gate is active and no inactive immediate enable blocks it.
- R8: When clear and preset are active together, clear wins. This holds for both the immediate and the gate-qualified kinds, and an immediate control outranks a gate-qualified one.
- R9: A control configured as absent has no effect on q, whatever level its input carries.
- R10: With QB_EN=1, qb is always the bitwise inverse of q. With QB_EN=0, qb is all zeros.
- R11: With INIT_EN=1, rst_n sampled low at a clock edge loads all zeros into the stored word, ahead of every other update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock on which the gated update is evaluated |
| rst_n | input | 1 | Synchronous active-low reset (effective when INIT_EN=1) |
| gate | input | 1 | Gate level, polarity set by GATE_ACT_LOW |
| en | input | 1 | Enable, mode and polarity set by EN_MODE |
| pre | input | 1 | Preset, mode and polarity set by PRE_MODE |
| clr | input | 1 | Clear, mode and polarity set by CLR_MODE |
| j | input | WIDTH | Per-bit set request, polarity set by J_ACT_LOW |
| k | input | WIDTH | Per-bit reset request, polarity set by K_ACT_LOW |
| q | output | WIDTH | Stored word, with immediate preset/clear override applied |
| qb | output | WIDTH | Inverse of q when QB_EN=1, else zeros |

## Verification
The bench runs three instances side by side, each with its own mix of polarities and control modes, on a long pseudo-random stream biased so that holds, toggles, blocked updates and colliding preset/clear all occur often. A design that reversed the enable priority would load a gate-qualified preset under an inactive immediate enable, or block it under an inactive gate-qualified enable. A design with preset and clear priority swapped would show PRE_VAL where CLR_VAL is expected. A design that registered the immediate controls would show the override one cycle late. A design that ignored a polarity setting, or let an absent control leak through, would show the wrong word on the first affected cycle.

// File: rtl/lk_pkg.sv
// Package lk_pkg
// Shared control-mode type and mode helper functions for the JK gated latch.
// Assumes every control input is a single bit.
package lk_pkg;

    typedef enum logic [2:0] {
        CTL_NONE     = 3'd0,
        CTL_ASYNC_HI = 3'd1,
        CTL_SYNC_HI  = 3'd2,
        CTL_ASYNC_LO = 3'd3,
        CTL_SYNC_LO  = 3'd4
    } ctl_mode_e;

    // now: immediate action requested; gated: gate-qualified action requested
    typedef struct packed {
        logic now;
        logic gated;
    } ctl_req_t;

    function automatic logic mode_async(ctl_mode_e m);
        return (m == CTL_ASYNC_HI) || (m == CTL_ASYNC_LO);
    endfunction

    function automatic logic mode_sync(ctl_mode_e m);
        return (m == CTL_SYNC_HI) || (m == CTL_SYNC_LO);
    endfunction

    function automatic logic mode_low(ctl_mode_e m);
        return (m == CTL_ASYNC_LO) || (m == CTL_SYNC_LO);
    endfunction

endpackage

// File: rtl/lk_ctl_decode.sv
// Module lk_ctl_decode
// Turns one raw control pin into immediate / gate-qualified requests.
// Assumes MODE is fixed at elaboration; an absent mode yields no request.
module lk_ctl_decode #(
    parameter lk_pkg::ctl_mode_e MODE = lk_pkg::CTL_NONE
) (
    input  logic             raw,
    output lk_pkg::ctl_req_t req
);
    localparam logic IS_ASYNC = lk_pkg::mode_async(MODE);
    localparam logic IS_SYNC  = lk_pkg::mode_sync(MODE);
    localparam logic IS_LOW   = lk_pkg::mode_low(MODE);

    logic asserted;

    // Normalize the pin so that 1 always means "asserted"
    assign asserted = raw ^ IS_LOW;

    // Route the asserted level to the kind of action the mode selects
    assign req.now   = IS_ASYNC & asserted;
    assign req.gated = IS_SYNC & asserted;

endmodule

// File: rtl/lk_polarity.sv
// Module lk_polarity
// Converts a vector to active-high form according to its configured polarity.
// Assumes ACT_LOW is constant; the active-high variant is a plain wire.
module lk_polarity #(
    parameter int WIDTH   = 4,
    parameter bit ACT_LOW = 1'b0
) (
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] norm
);
    generate
        if (ACT_LOW) begin : g_invert
            // Active-low input: invert every bit
            assign norm = ~raw;
        end else begin : g_pass
            // Active-high input: pass straight through
            assign norm = raw;
        end
    endgenerate

endmodule

// File: rtl/lk_jk_next.sv
// Module lk_jk_next
// Per-bit JK next-state function; each bit depends only on its own j,k pair.
// Assumes j and k are already normalized to active-high.
module lk_jk_next #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] jn,
    input  logic [WIDTH-1:0] kn,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            // hold / clear / set / invert selected by the (j,k) pair
            assign nxt[b] = jn[b] ? (kn[b] ? ~cur[b] : 1'b1)
                                  : (kn[b] ? 1'b0    : cur[b]);
        end
    endgenerate

endmodule

// File: rtl/lk_store.sv
// Module lk_store
// Holds the stored word and applies the priority chain for each clock edge:
// reset, immediate clear/preset, immediate enable, gate, gate-qualified
// clear/preset, gate-qualified enable, then the JK update.
// Immediate clear/preset also override the output combinationally.
module lk_store #(
    parameter int               WIDTH   = 4,
    parameter logic [WIDTH-1:0] PRE_VAL = '1,
    parameter logic [WIDTH-1:0] CLR_VAL = '0,
    parameter bit               INIT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lk_pkg::ctl_req_t clr_req,
    input  lk_pkg::ctl_req_t pre_req,
    input  logic             gate_on,
    input  logic             en_async_ok,
    input  logic             en_sync_ok,
    input  logic [WIDTH-1:0] jk_nxt,
    output logic [WIDTH-1:0] state,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    // Select the next stored value by control priority
    always_comb begin
        if (clr_req.now) begin
            state_d = CLR_VAL;
        end else if (pre_req.now) begin
            state_d = PRE_VAL;
        end else if (!en_async_ok || !gate_on) begin
            state_d = state_q;
        end else if (clr_req.gated) begin
            state_d = CLR_VAL;
        end else if (pre_req.gated) begin
            state_d = PRE_VAL;
        end else if (!en_sync_ok) begin
            state_d = state_q;
        end else begin
            state_d = jk_nxt;
        end
    end

    // Register the word; reset applies only when initialization is enabled
    always_ff @(posedge clk) begin
        if (!rst_n && INIT_EN) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;
    assign q     = clr_req.now ? CLR_VAL :
                   pre_req.now ? PRE_VAL : state_q;

endmodule

// File: rtl/jk_gated_latch.sv
// Module jk_gated_latch
// Configurable bit-vector JK storage updated while a gate level is active.
// Assumes one clock domain; the gate is evaluated once per clock edge.
module jk_gated_latch #(
    parameter int                WIDTH        = 4,
    parameter bit                J_ACT_LOW    = 1'b0,
    parameter bit                K_ACT_LOW    = 1'b0,
    parameter bit                GATE_ACT_LOW = 1'b0,
    parameter lk_pkg::ctl_mode_e EN_MODE      = lk_pkg::CTL_NONE,
    parameter lk_pkg::ctl_mode_e PRE_MODE     = lk_pkg::CTL_NONE,
    parameter lk_pkg::ctl_mode_e CLR_MODE     = lk_pkg::CTL_NONE,
    parameter logic [WIDTH-1:0]  PRE_VAL      = '1,
    parameter logic [WIDTH-1:0]  CLR_VAL      = '0,
    parameter bit                QB_EN        = 1'b1,
    parameter bit                INIT_EN      = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic             en,
    input  logic             pre,
    input  logic             clr,
    input  logic [WIDTH-1:0] j,
    input  logic [WIDTH-1:0] k,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] qb
);
    localparam logic EN_ASYNC = lk_pkg::mode_async(EN_MODE);
    localparam logic EN_SYNC  = lk_pkg::mode_sync(EN_MODE);

    logic             gate_on;
    logic [WIDTH-1:0] jn;
    logic [WIDTH-1:0] kn;
    logic [WIDTH-1:0] state;
    logic [WIDTH-1:0] jk_nxt;
    logic             en_async_ok;
    logic             en_sync_ok;
    lk_pkg::ctl_req_t en_req;
    lk_pkg::ctl_req_t pre_req;
    lk_pkg::ctl_req_t clr_req;

    // Gate polarity normalization
    assign gate_on = gate ^ GATE_ACT_LOW;

    lk_polarity #(.WIDTH(WIDTH), .ACT_LOW(J_ACT_LOW)) u_j_pol (
        .raw  (j),
        .norm (jn)
    );

    lk_polarity #(.WIDTH(WIDTH), .ACT_LOW(K_ACT_LOW)) u_k_pol (
        .raw  (k),
        .norm (kn)
    );

    lk_ctl_decode #(.MODE(EN_MODE)) u_en_dec (
        .raw (en),
        .req (en_req)
    );

    lk_ctl_decode #(.MODE(PRE_MODE)) u_pre_dec (
        .raw (pre),
        .req (pre_req)
    );

    lk_ctl_decode #(.MODE(CLR_MODE)) u_clr_dec (
        .raw (clr),
        .req (clr_req)
    );

    // An enable of a kind that is not configured never blocks
    assign en_async_ok = !EN_ASYNC || en_req.now;
    assign en_sync_ok  = !EN_SYNC  || en_req.gated;

    lk_jk_next #(.WIDTH(WIDTH)) u_jk (
        .jn  (jn),
        .kn  (kn),
        .cur (state),
        .nxt (jk_nxt)
    );

    lk_store #(
        .WIDTH   (WIDTH),
        .PRE_VAL (PRE_VAL),
        .CLR_VAL (CLR_VAL),
        .INIT_EN (INIT_EN)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_req     (clr_req),
        .pre_req     (pre_req),
        .gate_on     (gate_on),
        .en_async_ok (en_async_ok),
        .en_sync_ok  (en_sync_ok),
        .jk_nxt      (jk_nxt),
        .state       (state),
        .q           (q)
    );

    generate
        if (QB_EN) begin : g_qb
            // Complement output present
            assign qb = ~q;
        end else begin : g_no_qb
            // Complement output tied off
            assign qb = '0;
        end
    endgenerate

endmodule

// File: rtl/jk_gated_latch_chk.sv
// Module jk_gated_latch_chk
// Property checker for jk_gated_latch, attached through bind.
// Re-derives control meaning from the ports and parameters on its own.
module jk_gated_latch_chk #(
    parameter int                WIDTH        = 4,
    parameter bit                J_ACT_LOW    = 1'b0,
    parameter bit                K_ACT_LOW    = 1'b0,
    parameter bit                GATE_ACT_LOW = 1'b0,
    parameter lk_pkg::ctl_mode_e EN_MODE      = lk_pkg::CTL_NONE,
    parameter lk_pkg::ctl_mode_e PRE_MODE     = lk_pkg::CTL_NONE,
    parameter lk_pkg::ctl_mode_e CLR_MODE     = lk_pkg::CTL_NONE,
    parameter logic [WIDTH-1:0]  PRE_VAL      = '1,
    parameter logic [WIDTH-1:0]  CLR_VAL      = '0,
    parameter bit                QB_EN        = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate,
    input logic             en,
    input logic             pre,
    input logic             clr,
    input logic [WIDTH-1:0] j,
    input logic [WIDTH-1:0] k,
    input logic [WIDTH-1:0] q,
    input logic [WIDTH-1:0] qb
);
    logic             g_on;
    logic [WIDTH-1:0] jv;
    logic [WIDTH-1:0] kv;
    logic             a_clr, a_pre, s_clr, s_pre;
    logic             ea_ok, es_ok, quiet;

    // Interpret the pins the way the requirements describe them
    always_comb begin
        g_on  = (gate != GATE_ACT_LOW);
        jv    = J_ACT_LOW ? ~j : j;
        kv    = K_ACT_LOW ? ~k : k;
        a_clr = lk_pkg::mode_async(CLR_MODE) && (clr != lk_pkg::mode_low(CLR_MODE));
        a_pre = lk_pkg::mode_async(PRE_MODE) && (pre != lk_pkg::mode_low(PRE_MODE));
        s_clr = lk_pkg::mode_sync(CLR_MODE)  && (clr != lk_pkg::mode_low(CLR_MODE));
        s_pre = lk_pkg::mode_sync(PRE_MODE)  && (pre != lk_pkg::mode_low(PRE_MODE));
        ea_ok = !lk_pkg::mode_async(EN_MODE) || (en != lk_pkg::mode_low(EN_MODE));
        es_ok = !lk_pkg::mode_sync(EN_MODE)  || (en != lk_pkg::mode_low(EN_MODE));
        quiet = !a_clr && !a_pre;
    end

    assert_jk_rule_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (g_on && ea_ok && es_ok && !s_clr && !s_pre && quiet) |=>
        (a_clr || a_pre ||
         q == (($past(q) & ~$past(jv) & ~$past(kv)) | ($past(jv) & ~$past(kv)) |
               ($past(jv) & $past(kv) & ~$past(q)))));

    assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!g_on && quiet) |=> (a_clr || a_pre || q == $past(q)));

    assert_async_en_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ea_ok && quiet) |=> (a_clr || a_pre || q == $past(q)));

    assert_sync_en_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (g_on && ea_ok && !es_ok && !s_clr && !s_pre && quiet) |=>
        (a_clr || a_pre || q == $past(q)));

    assert_async_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        a_clr |-> (q == CLR_VAL));

    assert_async_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_pre && !a_clr) |-> (q == PRE_VAL));

    assert_sync_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (g_on && ea_ok && s_clr && quiet) |=> (a_clr || a_pre || q == CLR_VAL));

    assert_sync_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (g_on && ea_ok && s_pre && !s_clr && quiet) |=> (a_clr || a_pre || q == PRE_VAL));

    assert_qb_form_R10: assert property (@(posedge clk) disable iff (!rst_n)
        QB_EN ? (qb == ~q) : (qb == '0));

endmodule

bind jk_gated_latch jk_gated_latch_chk #(
    .WIDTH        (WIDTH),
    .J_ACT_LOW    (J_ACT_LOW),
    .K_ACT_LOW    (K_ACT_LOW),
    .GATE_ACT_LOW (GATE_ACT_LOW),
    .EN_MODE      (EN_MODE),
    .PRE_MODE     (PRE_MODE),
    .CLR_MODE     (CLR_MODE),
    .PRE_VAL      (PRE_VAL),
    .CLR_VAL      (CLR_VAL),
    .QB_EN        (QB_EN)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .gate  (gate),
    .en    (en),
    .pre   (pre),
    .clr   (clr),
    .j     (j),
    .k     (k),
    .q     (q),
    .qb    (qb)
);

// File: tb/jk_gated_latch_tb.sv
`timescale 1ns/1ps
// Bench for jk_gated_latch: three configurations driven by a biased
// pseudo-random sweep, each compared against an arithmetic model.
module jk_gated_latch_tb;
    import lk_pkg::*;

    localparam int W      = 4;
    localparam int NI     = 3;
    localparam int CYCLES = 3000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         g_r [NI];
    logic         e_r [NI];
    logic         p_r [NI];
    logic         c_r [NI];
    logic [W-1:0] j_r [NI];
    logic [W-1:0] k_r [NI];
    logic [W-1:0] q_o [NI];
    logic [W-1:0] qb_o[NI];

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    logic [W-1:0] m_st [NI];
    string        m_tag[NI];

    // Configuration table of the three instances
    function automatic ctl_mode_e cfg_en(int i);
        case (i) 0: return CTL_SYNC_HI; 1: return CTL_ASYNC_LO; default: return CTL_NONE; endcase
    endfunction
    function automatic ctl_mode_e cfg_pre(int i);
        case (i) 0: return CTL_SYNC_HI; 1: return CTL_ASYNC_LO; default: return CTL_ASYNC_HI; endcase
    endfunction
    function automatic ctl_mode_e cfg_clr(int i);
        case (i) 0: return CTL_SYNC_LO; 1: return CTL_ASYNC_HI; default: return CTL_NONE; endcase
    endfunction
    function automatic bit cfg_jl(int i); return (i != 0); endfunction
    function automatic bit cfg_kl(int i); return (i == 1); endfunction
    function automatic bit cfg_gl(int i); return (i == 1); endfunction
    function automatic bit cfg_qb(int i); return (i != 1); endfunction
    function automatic logic [W-1:0] cfg_pv(int i);
        case (i) 0: return 4'b1011; 1: return 4'b0110; default: return 4'b1100; endcase
    endfunction
    function automatic logic [W-1:0] cfg_cv(int i);
        case (i) 0: return 4'b0100; 1: return 4'b1001; default: return 4'b0011; endcase
    endfunction

    jk_gated_latch #(
        .WIDTH(W), .J_ACT_LOW(1'b0), .K_ACT_LOW(1'b0), .GATE_ACT_LOW(1'b0),
        .EN_MODE(CTL_SYNC_HI), .PRE_MODE(CTL_SYNC_HI), .CLR_MODE(CTL_SYNC_LO),
        .PRE_VAL(4'b1011), .CLR_VAL(4'b0100), .QB_EN(1'b1), .INIT_EN(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .gate(g_r[0]), .en(e_r[0]), .pre(p_r[0]), .clr(c_r[0]),
        .j(j_r[0]), .k(k_r[0]), .q(q_o[0]), .qb(qb_o[0])
    );

    jk_gated_latch #(
        .WIDTH(W), .J_ACT_LOW(1'b1), .K_ACT_LOW(1'b1), .GATE_ACT_LOW(1'b1),
        .EN_MODE(CTL_ASYNC_LO), .PRE_MODE(CTL_ASYNC_LO), .CLR_MODE(CTL_ASYNC_HI),
        .PRE_VAL(4'b0110), .CLR_VAL(4'b1001), .QB_EN(1'b0), .INIT_EN(1'b1)
    ) u_dut_a (
        .clk(clk), .rst_n(rst_n), .gate(g_r[1]), .en(e_r[1]), .pre(p_r[1]), .clr(c_r[1]),
        .j(j_r[1]), .k(k_r[1]), .q(q_o[1]), .qb(qb_o[1])
    );

    jk_gated_latch #(
        .WIDTH(W), .J_ACT_LOW(1'b1), .K_ACT_LOW(1'b0), .GATE_ACT_LOW(1'b0),
        .EN_MODE(CTL_NONE), .PRE_MODE(CTL_ASYNC_HI), .CLR_MODE(CTL_NONE),
        .PRE_VAL(4'b1100), .CLR_VAL(4'b0011), .QB_EN(1'b1), .INIT_EN(1'b1)
    ) u_dut_n (
        .clk(clk), .rst_n(rst_n), .gate(g_r[2]), .en(e_r[2]), .pre(p_r[2]), .clr(c_r[2]),
        .j(j_r[2]), .k(k_r[2]), .q(q_o[2]), .qb(qb_o[2])
    );

    // Compare one value and report a mismatch
    task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    function automatic bit asserted(ctl_mode_e m, logic x);
        return (m != CTL_NONE) && (x != mode_low(m));
    endfunction

    // Drive one instance from a random word, biased by normalized meaning
    task automatic drive(int i, logic [31:0] r);
        bit ga, ea, pa, ca;
        ga = r[0] | r[1];
        ea = |r[4:2];
        pa = (r[7:5] == 3'd0);
        ca = (r[10:8] == 3'd0);
        g_r[i] = ga ^ cfg_gl(i);
        e_r[i] = (cfg_en(i)  == CTL_NONE) ? r[19] : (ea ^ mode_low(cfg_en(i)));
        p_r[i] = (cfg_pre(i) == CTL_NONE) ? r[20] : (pa ^ mode_low(cfg_pre(i)));
        c_r[i] = (cfg_clr(i) == CTL_NONE) ? r[21] : (ca ^ mode_low(cfg_clr(i)));
        j_r[i] = r[14:11] ^ {W{cfg_jl(i)}};
        k_r[i] = r[18:15] ^ {W{cfg_kl(i)}};
    endtask

    // Reference model: current expected q and next stored word
    task automatic model(int i, output logic [W-1:0] qx, output logic [W-1:0] nx,
                         output string ctag, output string dtag);
        bit g, ac, ap, sc, sp, eao, eso;
        logic [W-1:0] jn, kn, st;
        st  = m_st[i];
        g   = g_r[i] ^ cfg_gl(i);
        jn  = j_r[i] ^ {W{cfg_jl(i)}};
        kn  = k_r[i] ^ {W{cfg_kl(i)}};
        ac  = mode_async(cfg_clr(i)) && asserted(cfg_clr(i), c_r[i]);
        ap  = mode_async(cfg_pre(i)) && asserted(cfg_pre(i), p_r[i]);
        sc  = mode_sync(cfg_clr(i))  && asserted(cfg_clr(i), c_r[i]);
        sp  = mode_sync(cfg_pre(i))  && asserted(cfg_pre(i), p_r[i]);
        eao = !mode_async(cfg_en(i)) || asserted(cfg_en(i), e_r[i]);
        eso = !mode_sync(cfg_en(i))  || asserted(cfg_en(i), e_r[i]);
        qx   = ac ? cfg_cv(i) : (ap ? cfg_pv(i) : st);
        ctag = (ac && ap) ? "R8" : ((ac || ap) ? "R6" : m_tag[i]);
        if (!rst_n)        begin nx = '0;        dtag = "R11"; end
        else if (ac)       begin nx = cfg_cv(i); dtag = ap ? "R8" : "R6"; end
        else if (ap)       begin nx = cfg_pv(i); dtag = "R6"; end
        else if (!eao)     begin nx = st;        dtag = "R4"; end
        else if (!g)       begin nx = st;        dtag = "R3"; end
        else if (sc)       begin nx = cfg_cv(i); dtag = sp ? "R8" : "R7"; end
        else if (sp)       begin nx = cfg_pv(i); dtag = "R7"; end
        else if (!eso)     begin nx = st;        dtag = "R5"; end
        else begin
            nx   = (~jn & ~kn & st) | (jn & ~kn) | (jn & kn & ~st);
            dtag = (i == 0) ? "R1" : ((i == 1) ? "R2" : "R9");
        end
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [W-1:0] qx, nx;
        string ctag, dtag;
        lfsr = 32'h1D2C3B4A;
        for (int i = 0; i < NI; i++) begin
            m_st[i]  = '0;
            m_tag[i] = "R11";
            drive(i, 32'h0);
        end
        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            @(negedge clk);
            rst_n = !((cyc < 3) || (cyc >= 1500 && cyc < 1502));
            lfsr  = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C11DB7 : 32'h0);
            for (int i = 0; i < NI; i++) begin
                logic [63:0] dbl;
                dbl = {lfsr, lfsr} >> (i * 5);
                drive(i, dbl[31:0]);
            end
            #1;
            for (int i = 0; i < NI; i++) begin
                model(i, qx, nx, ctag, dtag);
                if (cyc > 0) begin
                    chk(ctag, "q", q_o[i], qx);
                    chk("R10", "qb", qb_o[i], cfg_qb(i) ? ~qx : '0);
                end
                m_st[i]  = nx;
                m_tag[i] = dtag;
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #((CYCLES + 200) * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule